// File: doc/BRIEF.md
# Serial Line Receive Front End

This block sits at the line-side entry of an STM-0 receiver. Every cycle of the line clock (nominally 51.84 MHz) it takes one symbol from a pair of rail inputs and turns it into one recovered NRZ bit. A configuration input selects between two line formats. In plain NRZ format the data arrives on the positive rail alone. In dual-rail B3ZS format the decoder removes the zero-substitution codes, and it flags every alternate-mark-inversion violation that is not part of a substitution.

Alongside the data path, a loss-of-signal indication from the optical or electrical interface is integrated over a window of 128 or 4096 clock cycles. The filtered result is reported as a level. Every change of the filtered level sets a sticky alarm, and so does every bipolar violation. Each alarm has its own mask, and the unmasked alarms are combined into one interrupt line. Software removes an alarm with a write-one-to-clear pulse.

Top module: `line_rx_front`

## Requirements
- R1: With `nrz_mode` high, `rx_data` equals `rail_p` as it was three clock edges earlier. `rail_n` has no effect on the data, and no bipolar violation is ever flagged.
- R2: With `nrz_mode` low, a pulse on exactly one rail decodes to a 1 and a symbol with neither rail high decodes to a 0. The bit appears on `rx_data` three clock edges after the symbol was presented.
- R3: A violation that directly follows a zero symbol and itself follows a zero (the 0,0,V substitution) is decoded as three zero bits, with no violation flagged.
- R4: A violation that directly follows a zero symbol, where the symbol before that was a pulse of normal alternation (the B,0,V substitution), is decoded as three zero bits, with no violation flagged.
- R5: A pulse with the same polarity as the previous pulse, presented directly after a nonzero symbol, is a bipolar violation. It sets `bpv_alarm` and decodes as a 1.
- R6: A symbol with both rails high is a bipolar violation and decodes as a 1. It does not change the polarity reference used to judge later pulses.
- R7: After reset no polarity reference exists, so the first pulse is never treated as a violation or a substitution, whatever its rail.
- R8: `los_status` rises only after `raw_los` has been sampled high on W consecutive clock edges, and it changes at the edge that follows the W-th sample. W is 128 when `long_window` is low and 4096 when it is high.
- R9: `los_status` falls only after W consecutive low samples of `raw_los`. Any sample that agrees with the current `los_status` restarts the count from zero.
- R10: `los_alarm` is set at the edge where `los_status` changes in either direction, and `bpv_alarm` at the edge that samples a violation. Each alarm stays set until a one-cycle pulse on its clear input (`los_clr`, `bpv_clr`). A new event in the same cycle as the clear keeps the alarm set.
- R11: `irq` is high exactly when at least one alarm is set and its mask input (`los_mask`, `bpv_mask`) is low. A masked alarm stays latched and is still visible on its output.
- R12: While reset is applied and after it is released, `rx_data`, `los_status`, both alarms and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrz_mode | input | 1 | 1 selects single-rail NRZ input, 0 selects dual-rail B3ZS |
| rail_p | input | 1 | Positive-rail pulse, or the NRZ data in NRZ mode |
| rail_n | input | 1 | Negative-rail pulse; unused in NRZ mode |
| raw_los | input | 1 | Unfiltered loss-of-signal indication from the line interface |
| long_window | input | 1 | 1 selects the 4096-cycle LOS window, 0 the 128-cycle window |
| los_mask | input | 1 | 1 keeps the LOS alarm from driving the interrupt |
| bpv_mask | input | 1 | 1 keeps the violation alarm from driving the interrupt |
| los_clr | input | 1 | Write-one-to-clear pulse for the LOS alarm |
| bpv_clr | input | 1 | Write-one-to-clear pulse for the violation alarm |
| rx_data | output | 1 | Recovered NRZ data, three cycles behind the line |
| los_status | output | 1 | Integrated loss-of-signal level |
| los_alarm | output | 1 | Sticky alarm: the filtered LOS level changed |
| bpv_alarm | output | 1 | Sticky alarm: a bipolar violation was seen |
| irq | output | 1 | Interrupt, the OR of the set and unmasked alarms |

## Verification
The bench sends both substitution shapes and checks that each of the three positions is blanked. If the decoder cleared too few of the buffered bits, a stray 1 would leak out at the pulse of the B,0,V shape. Two error patterns are aimed at the polarity tracking. A first pulse after reset on the positive rail would be swallowed as a substitution if the reference polarity were taken from the reset value. A both-rails symbol that updated the reference would turn the next correct pulse into a false substitution. On the LOS side, the bench checks the exact edge at which the filtered level changes in both windows, and it checks that a single agreeing sample restarts the count; an off-by-one counter, or one that only pauses, would move the edge. The alarm tests cover the case where a clear and a new event arrive in the same cycle, and the case of a masked alarm that is still latched.

// File: rtl/lrf_pkg.sv
`timescale 1ns/1ps
package lrf_pkg;

  // Line symbol seen on the rail pair in one clock cycle.
  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_POS   = 2'd1,
    SYM_NEG   = 2'd2,
    SYM_DUAL  = 2'd3
  } line_sym_t;

  // Classify a rail pair: the positive rail is bit 0, the negative rail bit 1.
  function automatic line_sym_t classify_rails(input logic p, input logic n);
    return line_sym_t'({n, p});
  endfunction

  // A single-rail pulse is a violation when it repeats the polarity of the
  // previous pulse. There is no verdict without a reference.
  function automatic logic is_violation(input line_sym_t s,
                                        input logic      have_ref,
                                        input logic      ref_neg);
    logic v;
    v = 1'b0;
    if (have_ref) begin
      case (s)
        SYM_POS: v = !ref_neg;
        SYM_NEG: v = ref_neg;
        default: v = 1'b0;
      endcase
    end
    return v;
  endfunction

  // Integration window length, in samples, for the window select.
  function automatic int unsigned window_len(input logic        long_sel,
                                             input int unsigned short_len,
                                             input int unsigned long_len);
    return long_sel ? long_len : short_len;
  endfunction

endpackage

// File: rtl/lrf_b3zs_decoder.sv
`timescale 1ns/1ps
module lrf_b3zs_decoder
  import lrf_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_mode,
  input  logic rail_p,
  input  logic rail_n,
  output logic rx_data,
  output logic bpv_evt,
  output logic sub_evt
);

  // A substitution spans the violation plus the two symbols before it.
  localparam int SUB_SPAN = 3;

  line_sym_t sym;
  logic      viol;
  logic      cur_bit;
  logic      have_ref;
  logic      ref_neg;
  logic      prev_mark;
  logic      stg [LATENCY];
  logic      stg_nxt [LATENCY];

  always_comb begin
    sym     = classify_rails(rail_p, rail_n);
    viol    = !nrz_mode && is_violation(sym, have_ref, ref_neg);
    // A violation after a space closes a 00V or B0V code; after a mark it is an error.
    sub_evt = viol && !prev_mark;
    bpv_evt = !nrz_mode && ((viol && prev_mark) || (sym == SYM_DUAL));
    cur_bit = nrz_mode ? rail_p : (sym != SYM_SPACE);
  end

  // Delay line: on a substitution, clear the incoming bit and the two buffered bits.
  always_comb begin
    stg_nxt[0] = sub_evt ? 1'b0 : cur_bit;
    for (int i = 1; i < LATENCY; i++) begin
      stg_nxt[i] = (sub_evt && (i < SUB_SPAN)) ? 1'b0 : stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LATENCY; i++) stg[i] <= 1'b0;
    end else begin
      for (int i = 0; i < LATENCY; i++) stg[i] <= stg_nxt[i];
    end
  end

  // Polarity reference: updated only by single-rail pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref  <= 1'b0;
      ref_neg   <= 1'b0;
      prev_mark <= 1'b0;
    end else if (nrz_mode) begin
      have_ref  <= 1'b0;
      prev_mark <= 1'b0;
    end else begin
      prev_mark <= (sym != SYM_SPACE);
      if (sym == SYM_POS || sym == SYM_NEG) begin
        have_ref <= 1'b1;
        ref_neg  <= (sym == SYM_NEG);
      end
    end
  end

  assign rx_data = stg[LATENCY-1];

endmodule

// File: rtl/lrf_los_integrator.sv
`timescale 1ns/1ps
module lrf_los_integrator
  import lrf_pkg::*;
#(
  parameter int unsigned SHORT_WIN = 128,
  parameter int unsigned LONG_WIN  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_los,
  input  logic long_window,
  output logic los_status,
  output logic flip_evt
);

  localparam int CW = $clog2(LONG_WIN);

  logic          los_q;
  logic          differs;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] last_idx;

  assign last_idx = CW'(window_len(long_window, SHORT_WIN, LONG_WIN) - 1);
  assign differs  = (los_q != los_status);
  assign flip_evt = differs && (run_cnt >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q      <= 1'b0;
      run_cnt    <= '0;
      los_status <= 1'b0;
    end else begin
      los_q <= raw_los;
      // A sample that agrees with the current level restarts the run.
      if (!differs || flip_evt) run_cnt <= '0;
      else                      run_cnt <= run_cnt + 1'b1;
      if (flip_evt) los_status <= !los_status;
    end
  end

endmodule

// File: rtl/lrf_alarm_bank.sv
`timescale 1ns/1ps
module lrf_alarm_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] alarm,
  output logic         irq
);

  logic a_q [N];

  for (genvar g = 0; g < N; g++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          a_q[g] <= 1'b0;
      else if (set_evt[g]) a_q[g] <= 1'b1;   // a new event wins over a clear
      else if (clr[g])     a_q[g] <= 1'b0;
    end
    assign alarm[g] = a_q[g];
  end

  assign irq = |(alarm & ~mask);

endmodule

// File: rtl/line_rx_front.sv
`timescale 1ns/1ps
module line_rx_front #(
  parameter int unsigned SHORT_WIN = 128,
  parameter int unsigned LONG_WIN  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_mode,
  input  logic rail_p,
  input  logic rail_n,
  input  logic raw_los,
  input  logic long_window,
  input  logic los_mask,
  input  logic bpv_mask,
  input  logic los_clr,
  input  logic bpv_clr,
  output logic rx_data,
  output logic los_status,
  output logic los_alarm,
  output logic bpv_alarm,
  output logic irq
);

  localparam int DEC_LATENCY = 3;
  localparam int NUM_ALARMS  = 2;
  localparam int ALM_LOS     = 0;
  localparam int ALM_BPV     = 1;

  // Internal events brought out as named wires for the checker.
  logic bpv_evt;
  logic sub_evt;
  logic los_flip;

  logic [NUM_ALARMS-1:0] alm_set;
  logic [NUM_ALARMS-1:0] alm_clr;
  logic [NUM_ALARMS-1:0] alm_mask;
  logic [NUM_ALARMS-1:0] alm_q;

  lrf_b3zs_decoder #(.LATENCY(DEC_LATENCY)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .nrz_mode (nrz_mode),
    .rail_p   (rail_p),
    .rail_n   (rail_n),
    .rx_data  (rx_data),
    .bpv_evt  (bpv_evt),
    .sub_evt  (sub_evt)
  );

  lrf_los_integrator #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) u_los (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_los     (raw_los),
    .long_window (long_window),
    .los_status  (los_status),
    .flip_evt    (los_flip)
  );

  always_comb begin
    alm_set           = '0;
    alm_clr           = '0;
    alm_mask          = '0;
    alm_set[ALM_LOS]  = los_flip;
    alm_set[ALM_BPV]  = bpv_evt;
    alm_clr[ALM_LOS]  = los_clr;
    alm_clr[ALM_BPV]  = bpv_clr;
    alm_mask[ALM_LOS] = los_mask;
    alm_mask[ALM_BPV] = bpv_mask;
  end

  lrf_alarm_bank #(.N(NUM_ALARMS)) u_alm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (alm_set),
    .clr     (alm_clr),
    .mask    (alm_mask),
    .alarm   (alm_q),
    .irq     (irq)
  );

  assign los_alarm = alm_q[ALM_LOS];
  assign bpv_alarm = alm_q[ALM_BPV];

endmodule

// File: rtl/lrf_checker.sv
`timescale 1ns/1ps
module lrf_checker
  import lrf_pkg::*;
#(
  parameter int unsigned SHORT_WIN = 128,
  parameter int unsigned LONG_WIN  = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic nrz_mode,
  input logic rail_p,
  input logic raw_los,
  input logic long_window,
  input logic rx_data,
  input logic los_status,
  input logic los_flip,
  input logic bpv_evt,
  input logic sub_evt,
  input logic los_alarm,
  input logic bpv_alarm,
  input logic los_clr,
  input logic bpv_clr,
  input logic irq
);

  localparam int RW = $clog2(LONG_WIN) + 2;
  localparam logic [RW-1:0] RUN_MAX = '1;

  logic [RW-1:0] hi_run;
  logic [RW-1:0] lo_run;
  logic [RW-1:0] win;
  logic [1:0]    age;

  assign win = RW'(window_len(long_window, SHORT_WIN, LONG_WIN));

  // Runs of equal raw LOS samples, counted independently of the filter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      age    <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (raw_los) begin
        lo_run <= '0;
        if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != RUN_MAX) lo_run <= lo_run + 1'b1;
      end
    end
  end

  // R1: NRZ data passes with a three-edge delay
  p_nrz_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && nrz_mode && $past(nrz_mode) && $past(nrz_mode, 2) && $past(nrz_mode, 3))
      |-> (rx_data == $past(rail_p, 3)));

  // R3 and R4: a substitution leaves three zeros on the output
  p_sub_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_evt |=> !rx_data ##1 !rx_data ##1 !rx_data);

  // R5: a violation latches the alarm
  p_bpv_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_evt |=> bpv_alarm);

  // R8: a rise only after a full window of high samples
  p_los_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (los_flip && !los_status) |-> (hi_run >= win));

  // R9: a fall only after a full window of low samples
  p_los_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (los_flip && los_status) |-> (lo_run >= win));

  // R10: alarms are sticky until cleared
  p_bpv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_alarm && !bpv_clr) |=> bpv_alarm);

  p_los_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (los_alarm && !los_clr) |=> los_alarm);

  p_flip_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    los_flip |=> (los_alarm && $changed(los_status)));

  // R11: no interrupt without a latched alarm
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!los_alarm && !bpv_alarm) |-> !irq);

endmodule

bind line_rx_front lrf_checker #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nrz_mode    (nrz_mode),
  .rail_p      (rail_p),
  .raw_los     (raw_los),
  .long_window (long_window),
  .rx_data     (rx_data),
  .los_status  (los_status),
  .los_flip    (los_flip),
  .bpv_evt     (bpv_evt),
  .sub_evt     (sub_evt),
  .los_alarm   (los_alarm),
  .bpv_alarm   (bpv_alarm),
  .los_clr     (los_clr),
  .bpv_clr     (bpv_clr),
  .irq         (irq)
);

// File: tb/sim_line_rx_front.sv
`timescale 1ns/1ps
module sim_line_rx_front;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_W    = 128;
  localparam int LONG_W     = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nrz_mode = 1'b0;
  logic rail_p = 1'b0;
  logic rail_n = 1'b0;
  logic raw_los = 1'b0;
  logic long_window = 1'b0;
  logic los_mask = 1'b0;
  logic bpv_mask = 1'b0;
  logic los_clr = 1'b0;
  logic bpv_clr = 1'b0;
  logic rx_data, los_status, los_alarm, bpv_alarm, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  line_rx_front #(.SHORT_WIN(SHORT_W), .LONG_WIN(LONG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .nrz_mode(nrz_mode), .rail_p(rail_p), .rail_n(rail_n),
    .raw_los(raw_los), .long_window(long_window), .los_mask(los_mask), .bpv_mask(bpv_mask),
    .los_clr(los_clr), .bpv_clr(bpv_clr), .rx_data(rx_data), .los_status(los_status),
    .los_alarm(los_alarm), .bpv_alarm(bpv_alarm), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rail_p = 1'b0; rail_n = 1'b0; raw_los = 1'b0;
    los_clr = 1'b0; bpv_clr = 1'b0; los_mask = 1'b0; bpv_mask = 1'b0;
    long_window = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  // Symbols: '+' positive rail, '-' negative rail, 'B' both rails, '0' none.
  // Decoded bit j-2 is visible after the edge that captures symbol j.
  task automatic run_line(input string req, input string syms, input string expv, input logic exp_bpv);
    for (int j = 0; j < syms.len() + 2; j++) begin
      byte c;
      c = (j < syms.len()) ? syms[j] : "0";
      rail_p = (c == "+") || (c == "B");
      rail_n = (c == "-") || (c == "B");
      tick();
      if (j >= 2) check(req, $sformatf("rx_data bit %0d", j-2), rx_data, expv[j-2] == "1");
    end
    rail_p = 1'b0; rail_n = 1'b0;
    check(req, "bpv_alarm", bpv_alarm, exp_bpv);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    check("R12", "rx_data in reset", rx_data, 1'b0);
    check("R12", "los_status in reset", los_status, 1'b0);
    check("R12", "irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R12", "los_alarm after reset", los_alarm, 1'b0);
    check("R12", "bpv_alarm after reset", bpv_alarm, 1'b0);
  endtask

  task automatic t_nrz();
    do_reset();
    nrz_mode = 1'b1;
    // R1: the negative rail carries noise that must not reach the data
    run_line("R1", "B0-+B--0", "10011000", 1'b0);
    nrz_mode = 1'b0;
  endtask

  task automatic t_marks();
    do_reset();
    run_line("R2", "+0-0+-0+", "10101101", 1'b0);
  endtask

  task automatic t_sub_00v();
    do_reset();
    run_line("R3", "+-00-+", "110001", 1'b0);
  endtask

  task automatic t_sub_b0v();
    do_reset();
    run_line("R4", "+-+0+-", "110001", 1'b0);
  endtask

  task automatic t_bpv();
    do_reset();
    run_line("R5", "+--0", "1110", 1'b1);
    check("R11", "irq with unmasked bpv alarm", irq, 1'b1);
  endtask

  task automatic t_dual();
    do_reset();
    // R6: the last '-' is correct only if the dual symbol left the reference at '+'
    run_line("R6", "+B0-", "1101", 1'b1);
  endtask

  task automatic t_first_pulse();
    do_reset();
    run_line("R7", "00+0", "0010", 1'b0);
  endtask

  task automatic t_mask_clear();
    do_reset();
    bpv_mask = 1'b1;
    run_line("R11", "+--", "111", 1'b1);
    check("R11", "irq while masked", irq, 1'b0);
    bpv_mask = 1'b0;
    #1;
    check("R11", "irq after unmask", irq, 1'b1);
    bpv_clr = 1'b1;
    tick();
    bpv_clr = 1'b0;
    check("R10", "bpv_alarm after clear", bpv_alarm, 1'b0);
    check("R11", "irq after clear", irq, 1'b0);
  endtask

  task automatic t_set_wins();
    do_reset();
    rail_p = 1'b1; tick();
    rail_p = 1'b0; rail_n = 1'b1; tick();
    check("R10", "bpv_alarm before violation", bpv_alarm, 1'b0);
    bpv_clr = 1'b1;          // the violation and the clear share one cycle
    tick();
    bpv_clr = 1'b0; rail_n = 1'b0;
    check("R10", "bpv_alarm when set meets clear", bpv_alarm, 1'b1);
  endtask

  task automatic t_los_short();
    do_reset();
    raw_los = 1'b1;
    repeat (SHORT_W) tick();
    check("R8", "los_status after W high samples", los_status, 1'b0);
    tick();
    check("R8", "los_status one edge later", los_status, 1'b1);
    check("R10", "los_alarm on rise", los_alarm, 1'b1);
    check("R11", "irq from los alarm", irq, 1'b1);
    los_clr = 1'b1; tick(); los_clr = 1'b0;
    check("R10", "los_alarm after clear", los_alarm, 1'b0);
    // R9: one agreeing sample inside the low run restarts the count
    raw_los = 1'b0;
    repeat (SHORT_W - 1) tick();
    raw_los = 1'b1; tick();
    raw_los = 1'b0;
    repeat (SHORT_W) tick();
    check("R9", "los_status after restarted run", los_status, 1'b1);
    check("R9", "los_alarm not set early", los_alarm, 1'b0);
    tick();
    check("R9", "los_status falls", los_status, 1'b0);
    check("R10", "los_alarm on fall", los_alarm, 1'b1);
  endtask

  task automatic t_los_long();
    do_reset();
    long_window = 1'b1;
    raw_los = 1'b1;
    repeat (LONG_W) tick();
    check("R8", "long window: still low after W samples", los_status, 1'b0);
    tick();
    check("R8", "long window: rises one edge later", los_status, 1'b1);
    raw_los = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_nrz();
    t_marks();
    t_sub_00v();
    t_sub_b0v();
    t_bpv();
    t_dual();
    t_first_pulse();
    t_mask_clear();
    t_set_wins();
    t_los_short();
    t_los_long();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule